// File: doc/BRIEF.md
# Double-Precision Compare Unit

This block orders two packed 64-bit binary floating-point operands and reports the outcome as a four-bit condition code of negative, zero, carry and overflow flags. It also raises an invalid-operation flag for NaN operands. A request is a single-cycle `start` strobe. The unit captures its result at that same clock edge. In the following cycle it raises `done` for one cycle, and the flags are valid from that cycle on. The flags hold their value until the next request.

Two controls adapt each request:
- `quietSignals` makes a quiet NaN raise invalid as well as a signalling one. This serves the exception-raising compare variant.
- `useZero` replaces the second operand with +0. This serves compare-with-zero, and it works with either NaN policy.

For operands of equal sign, the ordering is found by an unsigned comparison of the packed words. When both signs are negative, the outcome is inverted.

Top module: `fpcmp_top`

## Requirements
- R1: After reset, `done` is 0, `nzcv` is 4'b0000 and `invalid` is 0.
- R2: `done` is 1 in exactly the cycle after a cycle with `start` high, and 0 in every other cycle.
- R3: Without `start`, `nzcv` and `invalid` keep their values, whatever the operands and controls do.
- R4: The `nzcv` field order is N=bit 3, Z=bit 2, C=bit 1, V=bit 0. Equal operands give 4'b0110, and identical bit patterns are equal.
- R5: +0 (64'h0) and -0 (64'h8000000000000000) compare equal, in either order.
- R6: When the signs (bit 63) differ and the operands are not both zero, the negative operand is the smaller. Less gives 4'b1000 and greater gives 4'b0010.
- R7: When both operands are positive, the larger unsigned packed word is the larger value. Infinity (exponent 2047, fraction 0) is ordered like any other value.
- R8: When both operands are negative, the unsigned comparison of the packed words is inverted.
- R9: An operand is a NaN when its exponent (bits 62:52) is 2047 and its fraction (bits 51:0) is non-zero. Any NaN operand gives the unordered code 4'b0011.
- R10: A NaN with fraction bit 51 equal to 0 is signalling and sets `invalid`. A quiet NaN (bit 51 = 1) does not set `invalid` while `quietSignals` is 0.
- R11: With `quietSignals` = 1, any NaN operand sets `invalid`.
- R12: With `useZero` = 1, the second operand is +0 and `opB` has no effect on `nzcv` or `invalid`.
- R13: `invalid` is 0 for every ordered result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe; operands and controls are sampled with it |
| opA | input | 64 | First packed operand |
| opB | input | 64 | Second packed operand |
| quietSignals | input | 1 | Quiet NaNs also raise invalid |
| useZero | input | 1 | Replace the second operand with +0 |
| done | output | 1 | One-cycle pulse, one cycle after `start` |
| nzcv | output | 4 | Condition flags {N,Z,C,V} |
| invalid | output | 1 | Invalid-operation flag |

## Verification
The bench builds the unit with its default field widths: an 11-bit exponent and a 52-bit fraction. With those widths, the encodings of ±0, ±1, ±2, ±infinity and both NaN kinds can be written directly as 64-bit constants. The scenarios exercise:
- the sign-flip ordering path for negative pairs;
- the signed-zero equality;
- quiet and signalling NaN handling under both policies;
- a signalling NaN parked on `opB` while `useZero` is set, which shows the substituted zero completely masks the second operand.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
  } ctrl_strobe_t;

  // per-operand classification
  typedef struct packed {
    logic isNan;
    logic isSignal;
    logic sign;
  } op_class_t;

  // condition codes, {N,Z,C,V}
  localparam logic [3:0] FLAG_LT = 4'b1000;
  localparam logic [3:0] FLAG_EQ = 4'b0110;
  localparam logic [3:0] FLAG_GT = 4'b0010;
  localparam logic [3:0] FLAG_UN = 4'b0011;
  localparam logic [3:0] FLAG_RST = 4'b0000;

endpackage

// File: rtl/fpcmp_ctrl.sv
module fpcmp_ctrl
  import fpcmp_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  output ctrl_strobe_t strobes,
  output logic         done
);

  logic doneQ;

  always_comb begin
    strobes = '0;
    strobes.capture = start;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) doneQ <= 1'b0;
    else       doneQ <= start;
  end

  assign done = doneQ;

  // R2: a request produces done in the next cycle
  a_r2_done_after_start: assert property (@(posedge clk) disable iff (!rstN)
    start |=> done);

  // R2: no done without a request
  a_r2_no_spurious_done: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> !done);

endmodule

// File: rtl/fpcmp_datapath.sv
module fpcmp_datapath
  import fpcmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_strobe_t        strobes,
  input  logic [EXP_W+FRAC_W:0] opA,
  input  logic [EXP_W+FRAC_W:0] opB,
  input  logic                quietSignals,
  input  logic                useZero,
  output logic [3:0]          nzcv,
  output logic                invalid
);

  localparam int DATA_W  = EXP_W + FRAC_W + 1;
  localparam int SIGN_B  = DATA_W - 1;
  localparam int EXP_HI  = DATA_W - 2;
  localparam int QUIET_B = FRAC_W - 1;
  localparam int N_OPS   = 2;

  logic [DATA_W-1:0] opSel [N_OPS];
  op_class_t         opCls [N_OPS];
  logic [N_OPS-1:0]  nanVec;
  logic [N_OPS-1:0]  raiseVec;

  assign opSel[0] = opA;
  assign opSel[1] = useZero ? '0 : opB;

  genvar gi;
  generate
    for (gi = 0; gi < N_OPS; gi++) begin : g_cls
      logic expAllOnes;
      logic fracNonZero;
      assign expAllOnes  = &opSel[gi][EXP_HI -: EXP_W];
      assign fracNonZero = |opSel[gi][FRAC_W-1:0];
      assign opCls[gi].isNan    = expAllOnes & fracNonZero;
      assign opCls[gi].isSignal = ~opSel[gi][QUIET_B];
      assign opCls[gi].sign     = opSel[gi][SIGN_B];
      assign nanVec[gi]   = opCls[gi].isNan;
      assign raiseVec[gi] = opCls[gi].isNan & (opCls[gi].isSignal | quietSignals);
    end
  endgenerate

  logic             unordered;
  logic             bothZero;
  logic             sameBits;
  logic             rawLess;
  logic [DATA_W-2:0] magOr;
  logic [3:0]       nzcvNext;
  logic             invalidNext;

  assign unordered = |nanVec;
  assign magOr     = opSel[0][DATA_W-2:0] | opSel[1][DATA_W-2:0];
  assign bothZero  = ~|magOr;
  assign sameBits  = (opSel[0] == opSel[1]);
  assign rawLess   = (opSel[0] < opSel[1]);

  always_comb begin
    if (unordered)                          nzcvNext = FLAG_UN;
    else if (sameBits || bothZero)          nzcvNext = FLAG_EQ;
    else if (opCls[0].sign != opCls[1].sign) nzcvNext = opCls[0].sign ? FLAG_LT : FLAG_GT;
    else if (opCls[0].sign ? !rawLess : rawLess) nzcvNext = FLAG_LT;
    else                                    nzcvNext = FLAG_GT;
  end

  assign invalidNext = |raiseVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nzcv    <= FLAG_RST;
      invalid <= 1'b0;
    end else if (strobes.capture) begin
      nzcv    <= nzcvNext;
      invalid <= invalidNext;
    end
  end

  // R3: result registers hold without a capture
  a_r3_hold_flags: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(nzcv) && $stable(invalid));

  // R9: a NaN operand leads to the unordered code
  a_r9_unordered_code: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture && unordered |=> nzcv == FLAG_UN);

  // R13: ordered outcomes never flag invalid
  a_r13_ordered_valid: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture && !unordered |=> !invalid);

  // R4: captured codes are one of the four legal encodings
  a_r4_legal_code: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> (nzcv == FLAG_LT) || (nzcv == FLAG_EQ) ||
                        (nzcv == FLAG_GT) || (nzcv == FLAG_UN));

endmodule

// File: rtl/fpcmp_top.sv
module fpcmp_top
  import fpcmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [EXP_W+FRAC_W:0] opA,
  input  logic [EXP_W+FRAC_W:0] opB,
  input  logic                  quietSignals,
  input  logic                  useZero,
  output logic                  done,
  output logic [3:0]            nzcv,
  output logic                  invalid
);

  ctrl_strobe_t strobes;

  fpcmp_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .strobes (strobes),
    .done    (done)
  );

  fpcmp_datapath #(
    .EXP_W  (EXP_W),
    .FRAC_W (FRAC_W)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .opA          (opA),
    .opB          (opB),
    .quietSignals (quietSignals),
    .useZero      (useZero),
    .nzcv         (nzcv),
    .invalid      (invalid)
  );

  // R1/R2: done only while out of reset and never with a pending stale code
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(rstN));

endmodule

// File: tb/fpcmp_top_tb_top.sv
module fpcmp_top_tb_top;

  localparam logic [63:0] P_ZERO = 64'h0000000000000000;
  localparam logic [63:0] N_ZERO = 64'h8000000000000000;
  localparam logic [63:0] P_ONE  = 64'h3FF0000000000000;
  localparam logic [63:0] P_TWO  = 64'h4000000000000000;
  localparam logic [63:0] N_ONE  = 64'hBFF0000000000000;
  localparam logic [63:0] N_TWO  = 64'hC000000000000000;
  localparam logic [63:0] P_INF  = 64'h7FF0000000000000;
  localparam logic [63:0] N_INF  = 64'hFFF0000000000000;
  localparam logic [63:0] Q_NAN  = 64'h7FF8000000000000;
  localparam logic [63:0] S_NAN  = 64'h7FF0000000000001;
  localparam logic [3:0]  C_LT = 4'b1000;
  localparam logic [3:0]  C_EQ = 4'b0110;
  localparam logic [3:0]  C_GT = 4'b0010;
  localparam logic [3:0]  C_UN = 4'b0011;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic        quietSignals = 1'b0;
  logic        useZero = 1'b0;
  logic        done;
  logic [3:0]  nzcv;
  logic        invalid;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  fpcmp_top dut_i (
    .clk(clk), .rstN(rstN), .start(start), .opA(opA), .opB(opB),
    .quietSignals(quietSignals), .useZero(useZero),
    .done(done), .nzcv(nzcv), .invalid(invalid)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // one request; checks flags and done pulse in the cycle after start
  task automatic compare(input logic [63:0] a, input logic [63:0] b, input bit q,
                         input bit z, input logic [3:0] expCode, input bit expInv,
                         input string req);
    @(negedge clk);
    opA = a; opB = b; quietSignals = q; useZero = z; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b1, {req, " done"}, {63'd0, done}, 64'd1);
    check(nzcv == expCode, {req, " nzcv"}, {60'd0, nzcv}, {60'd0, expCode});
    check(invalid == expInv, {req, " invalid"}, {63'd0, invalid}, {63'd0, expInv});
    @(negedge clk);
    check(done == 1'b0, "R2 done single cycle", {63'd0, done}, 64'd0);
  endtask

  task automatic testReset();
    check(done == 1'b0, "R1 done", {63'd0, done}, 64'd0);
    check(nzcv == 4'b0000, "R1 nzcv", {60'd0, nzcv}, 64'd0);
    check(invalid == 1'b0, "R1 invalid", {63'd0, invalid}, 64'd0);
  endtask

  task automatic testEqual();
    compare(P_ONE, P_ONE, 0, 0, C_EQ, 0, "R4 equal");
    compare(N_TWO, N_TWO, 0, 0, C_EQ, 0, "R4 equal negative");
    compare(P_ZERO, N_ZERO, 0, 0, C_EQ, 0, "R5 +0 vs -0");
    compare(N_ZERO, P_ZERO, 0, 0, C_EQ, 0, "R5 -0 vs +0");
  endtask

  task automatic testSigns();
    compare(N_ONE, P_ONE, 0, 0, C_LT, 0, "R6 neg<pos");
    compare(P_ZERO, N_ONE, 0, 0, C_GT, 0, "R6 pos>neg");
    compare(N_ZERO, P_TWO, 0, 0, C_LT, 0, "R6 -0<2");
  endtask

  task automatic testPositive();
    compare(P_ONE, P_TWO, 0, 0, C_LT, 0, "R7 1<2");
    compare(P_TWO, P_ONE, 0, 0, C_GT, 0, "R7 2>1");
    compare(P_INF, P_TWO, 0, 0, C_GT, 0, "R7 inf>2");
  endtask

  task automatic testNegative();
    compare(N_ONE, N_TWO, 0, 0, C_GT, 0, "R8 -1>-2");
    compare(N_TWO, N_ONE, 0, 0, C_LT, 0, "R8 -2<-1");
    compare(N_INF, N_ONE, 0, 0, C_LT, 0, "R8 -inf<-1");
  endtask

  task automatic testNan();
    compare(Q_NAN, P_ONE, 0, 0, C_UN, 0, "R9 qnan first R10 quiet no invalid");
    compare(P_ONE, Q_NAN, 0, 0, C_UN, 0, "R9 qnan second");
    compare(S_NAN, P_ONE, 0, 0, C_UN, 1, "R10 snan first");
    compare(P_TWO, S_NAN, 0, 0, C_UN, 1, "R10 snan second");
    compare(Q_NAN, P_ONE, 1, 0, C_UN, 1, "R11 qnan signals");
    compare(P_ONE, Q_NAN, 1, 0, C_UN, 1, "R11 qnan second signals");
    compare(P_INF, P_ONE, 1, 0, C_GT, 0, "R13 ordered with quietSignals");
  endtask

  task automatic testZeroSub();
    compare(P_ONE, S_NAN, 0, 1, C_GT, 0, "R12 opB ignored");
    compare(N_ONE, P_TWO, 0, 1, C_LT, 0, "R12 neg vs zero");
    compare(N_ZERO, Q_NAN, 1, 1, C_EQ, 0, "R12 -0 vs zero");
    compare(Q_NAN, N_TWO, 1, 1, C_UN, 1, "R12 R11 nan vs zero");
  endtask

  task automatic testHold();
    compare(P_ONE, P_TWO, 0, 0, C_LT, 0, "R3 setup");
    @(negedge clk);
    opA = S_NAN; opB = Q_NAN; quietSignals = 1'b1; useZero = 1'b1;
    repeat (2) @(negedge clk);
    check(nzcv == C_LT, "R3 hold nzcv", {60'd0, nzcv}, {60'd0, C_LT});
    check(invalid == 1'b0, "R3 hold invalid", {63'd0, invalid}, 64'd0);
    check(done == 1'b0, "R3 no done", {63'd0, done}, 64'd0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected below 20000", cycles);
        summary();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testEqual();
    testSigns();
    testPositive();
    testNegative();
    testNan();
    testZeroSub();
    testHold();
    summary();
  end

endmodule